// File: doc/BRIEF.md
# Reset-Phased Clock Divider Controller

This block derives the internal clocks of a processor subsystem from one input clock. It also walks the subsystem through reset in three phases. In the first phase the external reset pin is held low. In the second phase the pin has been released but an internal reset is held for a fixed number of cycles. In the third phase both resets are released. During the first two phases every derived clock runs at one eighth of the input rate. Once internal reset lifts, each derived clock moves to its own run-time ratio. The CPU clock moves to the full input rate, and the peripheral and memory-interface clocks move to half rate. The auxiliary output stays at one eighth in every phase.

Inside the input clock domain, each derived clock is a single-cycle enable pulse. For the pins, square-wave versions are provided. All ratios come from one free-running 3-bit counter, so the enables stay phase-aligned. A ratio change waits for the counter to wrap, so the pins never see a shortened pulse. The external memory clock pin carries either the internal memory-interface square wave or a separate external clock, chosen by a select input. The reset pin is synchronised through two flops. Pulling the pin low at any time forces phase 1 at once.

Top module: `rstphase_clkgen`

## Requirements
- R1: While `rst_pin_n` is low, `phase_o` reads 2'b01 and `int_rst_n` is 0. In this phase `cpu_clk_en`, `per_clk_en` and `mem_clk_en` pulse high together for one cycle in every eight.
- R2: `rst_pin_n` may be released between clock edges. The phase then still reads 2'b01 after the next two rising edges, and reads 2'b10 (stretch phase) after the third.
- R3: The stretch phase 2'b10 lasts exactly `STRETCH_CYCLES` input cycles, and the phase then becomes 2'b11. Throughout the stretch, `int_rst_n` stays 0 and the three enables keep the divide-by-8 lockstep of R1. Phase 2'b01 never goes straight to 2'b11.
- R4: In phase 2'b11, `int_rst_n` is 1. From the first counter wrap onward, `cpu_clk_en` is high every cycle, and `per_clk_en` and `mem_clk_en` are both high on every second cycle, in the same cycles as each other.
- R5: In all phases, `aux_clk_out` is a square wave of period 8 input cycles, high for 4 cycles and low for 4.
- R6: A ratio change takes effect only in the first cycle after `aux_clk_out` falls, which is the counter wrap. The divide-by-8 enable pulse always falls in the last cycle that `aux_clk_out` is high.
- R7: When `ext_src_sel` is 1, `mem_clk_out` follows `ext_clk_in`. When it is 0, `mem_clk_out` carries the internal memory-interface square wave.
- R8: Driving `rst_pin_n` low during phase 2'b10 or 2'b11 returns `phase_o` to 2'b01 and `int_rst_n` to 0 before the next clock edge. The enables fall back to divide-by-8 in that same cycle.
- R9: With `ext_src_sel` at 0, the internal memory-interface square wave is divide-by-8 with 50% duty before the switch of R6. After the switch it toggles every input cycle, which is divide-by-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock that all ratios derive from |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| ext_clk_in | input | 1 | Alternate source for the external memory clock pin |
| ext_src_sel | input | 1 | 0: internal memory clock on pin, 1: ext_clk_in on pin |
| int_rst_n | output | 1 | Stretched internal reset, active low |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| per_clk_en | output | 1 | Peripheral clock enable pulse |
| mem_clk_en | output | 1 | Memory-interface clock enable pulse |
| mem_clk_out | output | 1 | External memory clock pin |
| aux_clk_out | output | 1 | Auxiliary divide-by-8 square wave |
| phase_o | output | 2 | Reset phase: 01 pin held, 10 stretch, 11 run |

## Verification
Two events can land on the same cycle. One is the end of the stretch count, which releases internal reset. The other is the counter wrap, which is the only point where ratios change. The bench keeps its own counter model, locked to the falling edge of `aux_clk_out`. It predicts the enable and pin values from the phase seen in the wrap cycle. This makes a ratio switch one wrap early or one wrap late show up as a mismatch. A second pairing is tested by pulling the reset pin low mid-cycle during both stretch and run. In the same cycle, the phase and enables must fall back while the counter keeps its alignment.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [1:0] {
    PH_PIN     = 2'b01,
    PH_STRETCH = 2'b10,
    PH_RUN     = 2'b11
  } rst_phase_e;

  // Enable for a clock divided by 2**l: true when the low l counter bits are all ones.
  function automatic logic div_enable(input logic fast, input logic [7:0] c,
                                      input int unsigned fast_l, input int unsigned slow_l);
    logic [7:0] mf;
    logic [7:0] ms;
    mf = 8'((1 << fast_l) - 1);
    ms = 8'((1 << slow_l) - 1);
    return fast ? ((c & mf) == mf) : ((c & ms) == ms);
  endfunction

  // 50% square wave of a clock divided by 2**l (l >= 1); l == 0 yields 0.
  function automatic logic sq_bit(input logic [7:0] c, input int unsigned l);
    logic [7:0] s;
    s = c >> ((l == 0) ? 0 : (l - 1));
    return (l == 0) ? 1'b0 : s[0];
  endfunction

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkseq_phase.sv
module clkseq_phase
  import clkseq_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_ok,
  output rst_phase_e phase_o,
  output logic       run_o
);
  localparam int unsigned SW = $clog2(STRETCH_CYCLES + 1);

  rst_phase_e    phase_q;
  logic [SW-1:0] scnt_q;
  logic          stretch_done;

  assign stretch_done = (scnt_q == SW'(STRETCH_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PIN;
      scnt_q  <= '0;
    end else begin
      case (phase_q)
        PH_PIN: begin
          if (pin_ok) begin
            phase_q <= PH_STRETCH;
            scnt_q  <= '0;
          end
        end
        PH_STRETCH: begin
          if (!pin_ok)           phase_q <= PH_PIN;
          else if (stretch_done) phase_q <= PH_RUN;
          else                   scnt_q  <= scnt_q + 1'b1;
        end
        PH_RUN: begin
          if (!pin_ok) phase_q <= PH_PIN;
        end
        default: phase_q <= PH_PIN;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign run_o   = (phase_q == PH_RUN);

  AST_NO_STRETCH_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PIN) |=> (phase_q != PH_RUN)); // R3
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |=> (phase_q == PH_RUN)); // R4
endmodule

// File: rtl/clkseq_div.sv
module clkseq_div
  import clkseq_pkg::*;
#(
  parameter int unsigned SLOW_LOG2 = 3,
  parameter int unsigned CPU_L     = 0,
  parameter int unsigned PER_L     = 1,
  parameter int unsigned MEM_L     = 1,
  parameter int unsigned AUX_L     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req,
  output logic [2:0] en_o,
  output logic       mem_sq_o,
  output logic       aux_sq_o
);
  localparam int unsigned CW = SLOW_LOG2;
  localparam int unsigned LOGS [3] = '{CPU_L, PER_L, MEM_L};

  logic [CW-1:0] cnt_q;
  logic          fast_q;
  logic          wrap;

  // Free-running: every start value is a legal point in the cycle.
  always_ff @(posedge clk) cnt_q <= cnt_q + 1'b1;

  assign wrap = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fast_q <= 1'b0;
    else if (wrap) fast_q <= run_req;
  end

  for (genvar i = 0; i < 3; i++) begin : g_en
    assign en_o[i] = div_enable(fast_q, 8'(cnt_q), LOGS[i], SLOW_LOG2);
  end

  assign mem_sq_o = sq_bit(8'(cnt_q), fast_q ? MEM_L : SLOW_LOG2);
  assign aux_sq_o = sq_bit(8'(cnt_q), AUX_L);

  AST_RATIO_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q != $past(fast_q)) |-> (cnt_q == '0)); // R6

  if (PER_L > 0) begin : g_per_chk
    AST_FAST_PER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_q && en_o[1]) |=> !en_o[1]); // R4
  end
endmodule

// File: rtl/rstphase_clkgen.sv
module rstphase_clkgen
  import clkseq_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 256,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_in,
  input  logic       rst_pin_n,
  input  logic       ext_clk_in,
  input  logic       ext_src_sel,
  output logic       int_rst_n,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       mem_clk_en,
  output logic       mem_clk_out,
  output logic       aux_clk_out,
  output logic [1:0] phase_o
);
  logic       pin_ok;
  logic       run;
  rst_phase_e phase;
  logic [2:0] en;
  logic       mem_sq;

  clkseq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk_in), .rst_n(rst_pin_n), .sync_o(pin_ok)
  );

  clkseq_phase #(.STRETCH_CYCLES(STRETCH_CYCLES)) i_phase (
    .clk(clk_in), .rst_n(rst_pin_n), .pin_ok(pin_ok),
    .phase_o(phase), .run_o(run)
  );

  clkseq_div i_div (
    .clk(clk_in), .rst_n(rst_pin_n), .run_req(run),
    .en_o(en), .mem_sq_o(mem_sq), .aux_sq_o(aux_clk_out)
  );

  assign cpu_clk_en  = en[0];
  assign per_clk_en  = en[1];
  assign mem_clk_en  = en[2];
  assign int_rst_n   = run;
  assign phase_o     = phase;
  assign mem_clk_out = ext_src_sel ? ext_clk_in : mem_sq;

  AST_SLOW_LOCKSTEP: assert property (@(posedge clk_in) disable iff (!rst_pin_n)
    !int_rst_n |-> ((cpu_clk_en == per_clk_en) && (per_clk_en == mem_clk_en))); // R1
  AST_SLOW_GAP: assert property (@(posedge clk_in) disable iff (!rst_pin_n)
    (!int_rst_n && cpu_clk_en) |=> !cpu_clk_en); // R3
endmodule

// File: tb/test_rstphase_clkgen.sv
`timescale 1ns/100ps
module test_rstphase_clkgen;
  localparam int unsigned STRETCH = 48;

  logic clk_in = 1'b0;
  logic rst_pin_n = 1'b0;
  logic ext_clk_in = 1'b0;
  logic ext_src_sel = 1'b0;
  logic int_rst_n, cpu_clk_en, per_clk_en, mem_clk_en, mem_clk_out, aux_clk_out;
  logic [1:0] phase_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  rstphase_clkgen #(.STRETCH_CYCLES(STRETCH)) i_rstphase_clkgen (
    .clk_in(clk_in), .rst_pin_n(rst_pin_n), .ext_clk_in(ext_clk_in),
    .ext_src_sel(ext_src_sel), .int_rst_n(int_rst_n), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .mem_clk_en(mem_clk_en), .mem_clk_out(mem_clk_out),
    .aux_clk_out(aux_clk_out), .phase_o(phase_o)
  );

  always #2 clk_in = ~clk_in;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // External clock pattern: changes 1 ns after each rising edge
  int tick = 0;
  always @(posedge clk_in) begin
    tick <= tick + 1;
    ext_clk_in <= #1 tick[1] ^ tick[3];
  end

  // Reference model: counter phase locked to the falling edge of aux_clk_out
  logic [2:0] m = 3'd0;
  bit synced = 0;
  bit fast_m = 0;
  bit pend = 0;
  logic prev_aux = 1'b0;

  always @(negedge rst_pin_n) begin
    fast_m = 0;
    pend = 0;
  end

  always @(negedge clk_in) begin
    if (synced) begin
      m = m + 3'd1;
      if (m == 3'd0) fast_m = pend;
    end else if (prev_aux === 1'b1 && aux_clk_out === 1'b0) begin
      synced = 1;
      m = 3'd0;
    end
    prev_aux = aux_clk_out;
    if (synced && !done) begin
      chk((m == 3'd0) ? "R6 cpu" : (fast_m ? "R4 cpu" : "R1 cpu"),
          int'(cpu_clk_en), fast_m ? 1 : int'(m == 3'd7));
      chk(fast_m ? "R4 per" : "R1 per", int'(per_clk_en), fast_m ? int'(m[0]) : int'(m == 3'd7));
      chk(fast_m ? "R4 mem" : "R1 mem", int'(mem_clk_en), fast_m ? int'(m[0]) : int'(m == 3'd7));
      chk("R5 aux", int'(aux_clk_out), int'(m[2]));
      if (ext_src_sel)
        chk("R7 pin ext", int'(mem_clk_out), int'(ext_clk_in));
      else
        chk("R9 pin int", int'(mem_clk_out), fast_m ? int'(m[0]) : int'(m[2]));
      chk("R3 intrst", int'(int_rst_n), int'(phase_o == 2'b11));
      if (m == 3'd7) pend = (phase_o == 2'b11);
    end
  end

  // Release the pin at a falling edge; check sync latency and stretch length
  task automatic release_and_stretch(input bit full);
    int p2;
    rst_pin_n = 1'b1;
    @(posedge clk_in); @(posedge clk_in); @(negedge clk_in);
    chk("R2 still pin", int'(phase_o), 1);
    @(posedge clk_in); @(negedge clk_in);
    chk("R2 stretch", int'(phase_o), 2);
    p2 = 1;
    if (full) begin
      while (phase_o == 2'b10) begin
        @(negedge clk_in);
        if (phase_o == 2'b10) p2++;
      end
      chk("R3 length", p2, STRETCH);
      chk("R3 to run", int'(phase_o), 3);
      chk("R4 intrst", int'(int_rst_n), 1);
    end
  endtask

  task automatic reassert_mid;
    @(posedge clk_in); #1;
    rst_pin_n = 1'b0;
    #0.1;
    chk("R8 phase", int'(phase_o), 1);
    chk("R8 intrst", int'(int_rst_n), 0);
    chk("R8 cpu", int'(cpu_clk_en), int'(m == 3'd7));
  endtask

  initial begin
    repeat (3) @(negedge clk_in);
    chk("R1 phase", int'(phase_o), 1);
    chk("R1 intrst", int'(int_rst_n), 0);
    repeat (40) @(negedge clk_in);
    release_and_stretch(1);
    repeat (40) @(negedge clk_in);
    ext_src_sel = 1'b1;
    repeat (24) @(negedge clk_in);
    ext_src_sel = 1'b0;
    repeat (13) @(negedge clk_in);
    reassert_mid();                 // from run
    repeat (20) @(negedge clk_in);
    release_and_stretch(0);
    repeat (10) @(negedge clk_in);
    reassert_mid();                 // from stretch
    repeat (11) @(negedge clk_in);
    release_and_stretch(1);
    repeat (30) @(negedge clk_in);
    chk("R4 synced", int'(synced), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule